// File: doc/BRIEF.md
# Bus Match Break and Trigger Unit

This block sits behind a bus address/data comparator. Each cycle the comparator may report a condition match, together with the kind of bus cycle that matched: a CPU instruction fetch, a CPU data access or a DMA transfer. The block turns each match into two outputs.

The first output is an active-low trigger pin. Every match drives it low for a programmable number of clocks. A later match that arrives while the pin is still low restarts the count. The second output is a level break interrupt request to the CPU. It stays high until the CPU acknowledges it. A disable bit in the control register suppresses the interrupt while the trigger keeps working, so that matches can be watched from outside. Some fetch matches raise the trigger but never the interrupt: fetches that were started but not executed, and the first fetch at the target of a non-delayed branch or an exception entry. A standby input freezes the block, forces both outputs idle and blocks control register writes.

Top module: `brk_trig_unit`

## Requirements
- R1: Each accepted match drives `trig_n` low from the next cycle onward for W cycles, after which it returns high. W depends on `cfg_wdata[1:0]`: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 16 cycles.
- R2: If a match comes while `trig_n` is low, `trig_n` stays low and ends W cycles after that latest match.
- R3: A fetch match (`match_kind` = 00) that has `fetch_spec` = 1 still produces the trigger pulse but does not raise `brk_req`. `fetch_spec` = 1 marks an overrun fetch or a first fetch at a branch or exception target.
- R4: When the interrupt is enabled, the following matches set `brk_req` in the cycle after the match: a data access (01), a DMA cycle (10), a reserved kind (11), or a fetch with `fetch_spec` = 0.
- R5: While the disable bit (`cfg_wdata[2]`, written with `cfg_we`) is 1, no match raises `brk_req`, but every match still pulses `trig_n`.
- R6: `brk_req` stays high until `int_ack` is sampled high. A new qualifying match in the same cycle as `int_ack` takes priority and keeps the request high.
- R7: After reset the pulse width code is 00 and the disable bit is 0. While `stby` is 1, `trig_n` is forced high, `brk_req` is forced low, matches are ignored and control writes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stby | input | 1 | Module standby; 1 freezes the block and forces the outputs idle |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 3 | [1:0] pulse width code, [2] interrupt disable |
| match_valid | input | 1 | Comparator reports a match this cycle |
| match_kind | input | 2 | 00 fetch, 01 data, 10 DMA, 11 reserved |
| fetch_spec | input | 1 | Matched fetch is an overrun fetch or a first fetch at a branch target |
| int_ack | input | 1 | CPU acknowledge of the break request |
| trig_n | output | 1 | Active-low trigger pulse |
| brk_req | output | 1 | Break interrupt request level |

## Verification
The bench runs a single match under each of the four width codes and counts the low cycles. This separates the width encodings from each other and exposes off-by-one pulse lengths. Two matches spaced two cycles apart give a total low time of six cycles, which a pulse that is not restarted (four) or a pulse that is extended by addition would not produce. The bench then sweeps every combination of bus kind, speculative-fetch flag and disable bit. This shows that the interrupt qualification is separate from the trigger, which must pulse in every case. A match and an acknowledge in the same cycle, writes made while in standby, and entering standby in the middle of a pulse check the remaining orderings.

// File: rtl/brk_pkg.sv
package brk_pkg;
  localparam int CKS_W = 2;
  localparam int CNT_W = 5;

  typedef enum logic [1:0] {
    BUS_FETCH = 2'b00,
    BUS_DATA  = 2'b01,
    BUS_DMA   = 2'b10,
    BUS_RSVD  = 2'b11
  } bus_kind_e;

  // Pulse width in clocks for a width code.
  function automatic logic [CNT_W-1:0] cks_width(input logic [CKS_W-1:0] cks);
    logic [CNT_W-1:0] w;
    case (cks)
      2'b00:   w = CNT_W'(1);
      2'b01:   w = CNT_W'(4);
      2'b10:   w = CNT_W'(8);
      default: w = CNT_W'(16);
    endcase
    return w;
  endfunction

  // Whether a match may raise the break interrupt.
  function automatic logic irq_qualifies(input logic [1:0] kind, input logic spec,
                                         input logic dis);
    return !dis && !((kind == BUS_FETCH) && spec);
  endfunction
endpackage

// File: rtl/brk_cfg_reg.sv
module brk_cfg_reg
  import brk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             we,
  input  logic [CKS_W:0]   wdata,
  output logic [CKS_W-1:0] cks,
  output logic             int_dis
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cks     <= '0;
      int_dis <= 1'b0;
    end else if (en && we) begin
      cks     <= wdata[CKS_W-1:0];
      int_dis <= wdata[CKS_W];
    end
  end

  // R7: the register is frozen while the block is in standby
  p_cfg_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(cks) && $stable(int_dis)));
endmodule

// File: rtl/brk_pulse_gen.sv
module brk_pulse_gen
  import brk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             hit,
  input  logic [CNT_W-1:0] width,
  output logic             trig_n
);
  localparam logic [CNT_W-1:0] MAX_W = CNT_W'(16);

  logic [CNT_W-1:0] cnt;
  logic             pulse_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!en)          cnt <= '0;
    else if (hit)          cnt <= width;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign pulse_on = en && (cnt != '0);
  assign trig_n   = !pulse_on;

  // R1: a match drives the pin low in the next cycle
  p_low_after_hit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (en && hit) |=> (!trig_n || !en));
  // R1: the pulse ends once the last counted cycle has passed
  p_pulse_ends_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !hit && cnt == CNT_W'(1)) |=> trig_n);
  // R2: the counter never exceeds the widest code
  always_comb begin
    if (rst_n) p_cnt_bound_r2: assert (cnt <= MAX_W);
  end
endmodule

// File: rtl/brk_irq_ctl.sv
module brk_irq_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic set,
  input  logic ack,
  output logic req
);
  logic req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      req_q <= 1'b0;
    else if (!en)    req_q <= 1'b0;
    else if (set)    req_q <= 1'b1;
    else if (ack)    req_q <= 1'b0;
  end

  assign req = req_q && en;

  // R6: an acknowledge without a new match clears the request
  p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && ack && !set) |=> !req_q);
  // R6: a new match wins over a simultaneous acknowledge
  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && set) |=> req_q);
  // R6: without an acknowledge, a raised request is held
  p_req_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && req_q && !ack) |=> (req_q || !en));
endmodule

// File: rtl/brk_trig_unit.sv
module brk_trig_unit
  import brk_pkg::*;
#(
  parameter int CFG_W = CKS_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stby,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             match_valid,
  input  logic [1:0]       match_kind,
  input  logic             fetch_spec,
  input  logic             int_ack,
  output logic             trig_n,
  output logic             brk_req
);
  logic             run_en;
  logic [CKS_W-1:0] cks;
  logic             int_dis;
  logic [CNT_W-1:0] pulse_width;
  logic             trig_hit;
  logic             irq_set;

  assign run_en      = !stby;
  assign pulse_width = cks_width(cks);
  assign trig_hit    = match_valid;
  assign irq_set     = match_valid && irq_qualifies(match_kind, fetch_spec, int_dis);

  brk_cfg_reg u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (run_en),
    .we     (cfg_we),
    .wdata  (cfg_wdata),
    .cks    (cks),
    .int_dis(int_dis)
  );

  brk_pulse_gen u_pulse (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (run_en),
    .hit   (trig_hit),
    .width (pulse_width),
    .trig_n(trig_n)
  );

  brk_irq_ctl u_irq (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (run_en),
    .set  (irq_set),
    .ack  (int_ack),
    .req  (brk_req)
  );

  // R3: a speculative or branch-target fetch match never raises the request
  p_spec_fetch_noirq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!stby && !brk_req && match_valid && match_kind == BUS_FETCH && fetch_spec)
      |=> !brk_req);
  // R4: enabled data, DMA and ordinary fetch matches raise the request
  p_match_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!stby && !int_dis && match_valid && !(match_kind == BUS_FETCH && fetch_spec))
      |=> (brk_req || stby));
  // R5: with the disable bit set, the request cannot rise
  p_dis_noirq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!brk_req && int_dis) |=> !brk_req);
  // R7: standby keeps both outputs idle
  p_standby_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stby |-> (trig_n && !brk_req));
endmodule

// File: tb/brk_trig_unit_bench.sv
module brk_trig_unit_bench;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n, stby, cfg_we, match_valid, fetch_spec, int_ack;
  logic [2:0] cfg_wdata;
  logic [1:0] match_kind;
  logic       trig_n, brk_req;
  int         n_run = 0, n_fail = 0;

  always #(PERIOD/2) clk = ~clk;

  brk_trig_unit u_brk_trig_unit (
    .clk(clk), .rst_n(rst_n), .stby(stby), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .match_valid(match_valid), .match_kind(match_kind), .fetch_spec(fetch_spec),
    .int_ack(int_ack), .trig_n(trig_n), .brk_req(brk_req)
  );

  function automatic int exp_width(input int code);
    return (code == 0) ? 1 : (4 << (code - 1));
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wcfg(input int code, input bit dis);
    cfg_we = 1'b1;
    cfg_wdata = {dis, 2'(code)};
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic ack_pulse();
    int_ack = 1'b1;
    @(negedge clk);
    int_ack = 1'b0;
  endtask

  // One match, then count low cycles over 20 samples; req sampled after match edge
  task automatic measure(input logic [1:0] kind, input bit spec,
                         output int lows, output bit req_seen);
    match_valid = 1'b1; match_kind = kind; fetch_spec = spec;
    @(negedge clk);
    match_valid = 1'b0; fetch_spec = 1'b0;
    req_seen = brk_req;
    lows = 0;
    for (int i = 0; i < 20; i++) begin
      if (!trig_n) lows++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(PERIOD * 20000);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int lows;
    bit rq;
    rst_n = 0; stby = 1; cfg_we = 0; cfg_wdata = '0; match_valid = 0;
    match_kind = 2'b01; fetch_spec = 0; int_ack = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(trig_n == 1'b1, "R7 reset trig_n", int'(trig_n), 1);
    chk(brk_req == 1'b0, "R7 reset brk_req", int'(brk_req), 0);

    // Standby: write and match are ignored
    wcfg(3, 1'b1);
    measure(2'b01, 1'b0, lows, rq);
    chk(lows == 0, "R7 standby trigger", lows, 0);
    chk(rq == 1'b0, "R7 standby req", int'(rq), 0);
    stby = 1'b0;
    @(negedge clk);
    measure(2'b01, 1'b0, lows, rq);
    chk(lows == 1, "R7 write in standby ignored (width)", lows, 1);
    chk(rq == 1'b1, "R7 write in standby ignored (disable)", int'(rq), 1);
    chk(brk_req == 1'b1, "R6 request held without ack", int'(brk_req), 1);
    ack_pulse();
    chk(brk_req == 1'b0, "R6 ack clears", int'(brk_req), 0);

    // Width sweep
    for (int c = 0; c < 4; c++) begin
      wcfg(c, 1'b1);
      measure(2'b01, 1'b0, lows, rq);
      chk(lows == exp_width(c), $sformatf("R1 width code %0d", c), lows, exp_width(c));
      chk(rq == 1'b0, $sformatf("R5 disabled req code %0d", c), int'(rq), 0);
    end

    // Retrigger: matches two cycles apart at width 4
    wcfg(1, 1'b1);
    lows = 0;
    match_valid = 1'b1; match_kind = 2'b10;
    @(negedge clk); if (!trig_n) lows++;
    match_valid = 1'b0;
    @(negedge clk); if (!trig_n) lows++;
    match_valid = 1'b1;
    @(negedge clk); if (!trig_n) lows++;
    match_valid = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!trig_n) lows++;
    end
    chk(lows == 2 + exp_width(1), "R2 retrigger low cycles", lows, 2 + exp_width(1));

    // Qualification sweep
    for (int d = 0; d < 2; d++) begin
      for (int k = 0; k < 4; k++) begin
        for (int s = 0; s < 2; s++) begin
          bit expq;
          string tag;
          expq = (d == 0) && !(k == 0 && s == 1);
          tag = (d == 1) ? "R5" : ((k == 0 && s == 1) ? "R3" : "R4");
          wcfg(0, d[0]);
          measure(2'(k), s[0], lows, rq);
          chk(lows == 1, $sformatf("%s trigger d=%0d k=%0d s=%0d", tag, d, k, s), lows, 1);
          chk(rq == expq, $sformatf("%s req d=%0d k=%0d s=%0d", tag, d, k, s),
              int'(rq), int'(expq));
          ack_pulse();
        end
      end
    end

    // Match and ack in the same cycle
    wcfg(0, 1'b0);
    match_valid = 1'b1; match_kind = 2'b01; int_ack = 1'b1;
    @(negedge clk);
    match_valid = 1'b0; int_ack = 1'b0;
    chk(brk_req == 1'b1, "R6 match wins over ack", int'(brk_req), 1);
    ack_pulse();
    chk(brk_req == 1'b0, "R6 later ack clears", int'(brk_req), 0);

    // Standby entered mid-pulse
    wcfg(3, 1'b0);
    match_valid = 1'b1; match_kind = 2'b01;
    @(negedge clk);
    match_valid = 1'b0;
    chk(trig_n == 1'b0, "R1 pulse started", int'(trig_n), 0);
    stby = 1'b1;
    #1;
    chk(trig_n == 1'b1, "R7 standby forces trig high", int'(trig_n), 1);
    chk(brk_req == 1'b0, "R7 standby forces req low", int'(brk_req), 0);
    @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule